// File: doc/BRIEF.md
# Radio Packet Framer

The framer turns a continuous stream of compressed video bytes into fixed-size radio packets and sends each packet out one bit at a time, so that it can feed a forward-error-correction encoder. The bytes are held in a first-word-fall-through FIFO upstream of the framer. The framer watches the FIFO fill level and pops the FIFO itself. A packet is started only when a whole payload is already stored, so a packet that has begun never has to wait for data.

Each packet is laid out as follows:
- a fixed 32-bit access code, which lets the receiver find bit and byte alignment;
- an 8-bit destination identifier, taken from an input port when the packet starts;
- a 16-bit sequence number;
- the payload (256 bytes by default);
- a 16-bit CRC, computed over everything after the access code.

Every field leaves most-significant bit first. The serial output uses a valid/ready handshake, and the downstream side may stall on any bit.

Top module: `pf_packet_framer`

## Requirements
- R1: While reset is applied and on the first cycle after it, `out_valid` and `fifo_rd_en` are low.
- R2: A packet begins only in a cycle where `fifo_level` is at least the payload size. Below that, `out_valid` stays low and the FIFO is never popped.
- R3: The first 32 bits of every packet are the access code 0x1ACFFC1D, sent MSB first.
- R4: Bits 32..39 carry the destination identifier. This is the value on `dest_id` in the cycle the packet starts, and later changes of `dest_id` do not affect a packet already under way.
- R5: Bits 40..55 carry the sequence number, MSB first. It is 0 for the first packet after reset and rises by one per packet, modulo 65536.
- R6: The payload follows the header and holds exactly 256 FIFO bytes in FIFO order, each MSB first. Each packet pops the FIFO exactly 256 times.
- R7: The last 16 bits are a CRC over the header and payload bits. The CRC uses polynomial 0x1021 and start value 0xFFFF, with no reflection and no final inversion, and is sent MSB first.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold their values into the next cycle.
- R9: A packet is exactly 2120 bits long. After its last bit is accepted, `out_valid` drops for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_level | input | 12 | Number of bytes held in the upstream FIFO |
| fifo_data | input | 8 | Head byte of the FIFO (first-word fall-through) |
| fifo_rd_en | output | 1 | Pops the FIFO head at the clock edge |
| dest_id | input | 8 | Destination identifier for the next packet |
| out_valid | output | 1 | Serial bit is valid |
| out_bit | output | 1 | Serial packet bit |
| out_ready | input | 1 | Downstream accepts the bit |

## Verification
The hardest situation to reach is a stall that lands on a field boundary. Examples are the bit that ends the last payload byte, where the CRC high byte is loaded from the CRC value that includes that same bit, and a pop that happens while `out_ready` toggles. The bench drives `out_ready` from a pseudo-random sequence for an entire packet, so stalls fall on every kind of byte boundary. It then recomputes the CRC from the bytes it pushed. A second hard case is a destination change in the cycle right after the packet starts, before the header has left. The bench watches for `out_valid` to rise and changes `dest_id` at once.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic [1:0] {
      FLD_CODE = 2'd0,
      FLD_HDR  = 2'd1,
      FLD_PAY  = 2'd2,
      FLD_CRC  = 2'd3
   } fld_kind_e;

   // one serial CRC step, MSB-first shift register form
   function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                              input logic        b,
                                              input logic [15:0] poly);
      logic fb;
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
   endfunction

endpackage

// File: rtl/pf_crc16_bit.sv
module pf_crc16_bit #(
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        init,
   input  logic        en,
   input  logic        bit_in,
   output logic [15:0] crc_q,
   output logic [15:0] crc_next
);

   assign crc_next = pf_pkg::crc16_step(crc_q, bit_in, POLY);

   always_ff @(posedge clk) begin
      if (rst || init) crc_q <= SEED;
      else if (en)     crc_q <= crc_next;
   end

endmodule

// File: rtl/pf_bit_shifter.sv
module pf_bit_shifter (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [7:0] load_byte,
   input  logic       advance,
   output logic       bit_out,
   output logic       valid,
   output logic       last
);

   logic [7:0] sh_q;
   logic [2:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         cnt_q <= '0;
         valid <= 1'b0;
      end else if (load) begin
         sh_q  <= load_byte;
         cnt_q <= '0;
         valid <= 1'b1;
      end else if (advance) begin
         if (cnt_q == 3'd7) begin
            valid <= 1'b0;
         end else begin
            sh_q  <= {sh_q[6:0], 1'b0};
            cnt_q <= cnt_q + 3'd1;
         end
      end
   end

   assign bit_out = sh_q[7];
   assign last    = (cnt_q == 3'd7);

endmodule

// File: rtl/pf_field_sel.sv
module pf_field_sel #(
   parameter int          CODE_W        = 32,
   parameter logic [CODE_W-1:0] ACCESS_CODE = 32'h1ACF_FC1D,
   parameter int          DEST_W        = 8,
   parameter int          SEQ_W         = 16,
   parameter int          PAYLOAD_BYTES = 256,
   parameter int          IDX_W         = 9
) (
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic [DEST_W-1:0] dest_val,
   input  logic [SEQ_W-1:0]  seq_val,
   input  logic [7:0]        pay_byte,
   input  logic [7:0]        crc_hi,
   input  logic [7:0]        crc_lo,
   output logic [7:0]        byte_out,
   output pf_pkg::fld_kind_e kind
);

   localparam int CODE_B  = CODE_W / 8;
   localparam int DEST_B  = DEST_W / 8;
   localparam int SEQ_B   = SEQ_W / 8;
   localparam int DEST_AT = CODE_B;
   localparam int SEQ_AT  = CODE_B + DEST_B;
   localparam int PAY_AT  = SEQ_AT + SEQ_B;
   localparam int CRC_AT  = PAY_AT + PAYLOAD_BYTES;

   logic [7:0] code_b [CODE_B];
   logic [7:0] dest_b [DEST_B];
   logic [7:0] seq_b  [SEQ_B];

   for (genvar g = 0; g < CODE_B; g++) begin : g_code
      assign code_b[g] = ACCESS_CODE[CODE_W-1-8*g -: 8];
   end
   for (genvar g = 0; g < DEST_B; g++) begin : g_dest
      assign dest_b[g] = dest_val[DEST_W-1-8*g -: 8];
   end
   for (genvar g = 0; g < SEQ_B; g++) begin : g_seq
      assign seq_b[g] = seq_val[SEQ_W-1-8*g -: 8];
   end

   always_comb begin
      byte_out = crc_lo;
      kind     = pf_pkg::FLD_CRC;
      if (sel_idx < IDX_W'(DEST_AT)) begin
         kind = pf_pkg::FLD_CODE;
         for (int k = 0; k < CODE_B; k++)
            if (sel_idx == IDX_W'(k)) byte_out = code_b[k];
      end else if (sel_idx < IDX_W'(PAY_AT)) begin
         kind = pf_pkg::FLD_HDR;
         for (int k = 0; k < DEST_B; k++)
            if (sel_idx == IDX_W'(DEST_AT + k)) byte_out = dest_b[k];
         for (int k = 0; k < SEQ_B; k++)
            if (sel_idx == IDX_W'(SEQ_AT + k)) byte_out = seq_b[k];
      end else if (sel_idx < IDX_W'(CRC_AT)) begin
         kind     = pf_pkg::FLD_PAY;
         byte_out = pay_byte;
      end else if (sel_idx == IDX_W'(CRC_AT)) begin
         byte_out = crc_hi;
      end
   end

endmodule

// File: rtl/pf_packet_framer.sv
module pf_packet_framer #(
   parameter int          PAYLOAD_BYTES = 256,
   parameter int          CODE_W        = 32,
   parameter logic [CODE_W-1:0] ACCESS_CODE = 32'h1ACF_FC1D,
   parameter int          DEST_W        = 8,
   parameter int          SEQ_W         = 16,
   parameter int          LEVEL_W       = 12,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_SEED      = 16'hFFFF
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic [7:0]         fifo_data,
   output logic               fifo_rd_en,
   input  logic [DEST_W-1:0]  dest_id,
   output logic               out_valid,
   output logic               out_bit,
   input  logic               out_ready
);

   localparam int CODE_B  = CODE_W / 8;
   localparam int HDR_END = CODE_B + DEST_W / 8 + SEQ_W / 8;
   localparam int PAY_END = HDR_END + PAYLOAD_BYTES;
   localparam int PKT_B   = PAY_END + 2;
   localparam int IDX_W   = $clog2(PKT_B + 1);

   if (CODE_W % 8 != 0 || CODE_W < 8) begin : g_bad_code
      $error("access code width must be a positive multiple of 8");
   end
   if (DEST_W % 8 != 0 || SEQ_W % 8 != 0) begin : g_bad_hdr
      $error("header fields must be whole bytes");
   end
   if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES >= (1 << LEVEL_W)) begin : g_bad_pay
      $error("payload size must fit the fifo level width");
   end

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q, idx_nxt, sel_idx;
   logic [DEST_W-1:0] dest_q;
   logic [SEQ_W-1:0]  seq_q;
   logic              fire, last, byte_done, pkt_end, start, load;
   logic [7:0]        load_byte;
   logic [15:0]       crc_q, crc_next;
   logic              crc_en;
   pf_pkg::fld_kind_e sel_kind;

   assign idx_nxt   = idx_q + IDX_W'(1);
   assign fire      = out_valid & out_ready;
   assign byte_done = fire & last;
   assign pkt_end   = byte_done & (idx_q == IDX_W'(PKT_B - 1));
   assign start     = ~busy_q & (fifo_level >= LEVEL_W'(PAYLOAD_BYTES));
   assign sel_idx   = busy_q ? idx_nxt : '0;
   assign load      = start | (byte_done & ~pkt_end);
   assign fifo_rd_en = busy_q & byte_done & ~pkt_end & (sel_kind == pf_pkg::FLD_PAY);
   assign crc_en    = fire & (idx_q >= IDX_W'(CODE_B)) & (idx_q < IDX_W'(PAY_END));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         dest_q <= '0;
         seq_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         dest_q <= dest_id;
      end else if (pkt_end) begin
         busy_q <= 1'b0;
         seq_q  <= seq_q + SEQ_W'(1);
      end else if (byte_done) begin
         idx_q  <= idx_nxt;
      end
   end

   pf_field_sel #(
      .CODE_W(CODE_W), .ACCESS_CODE(ACCESS_CODE), .DEST_W(DEST_W),
      .SEQ_W(SEQ_W), .PAYLOAD_BYTES(PAYLOAD_BYTES), .IDX_W(IDX_W)
   ) u_sel (
      .sel_idx(sel_idx), .dest_val(dest_q), .seq_val(seq_q),
      .pay_byte(fifo_data), .crc_hi(crc_next[15:8]), .crc_lo(crc_q[7:0]),
      .byte_out(load_byte), .kind(sel_kind)
   );

   pf_crc16_bit #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
      .clk(clk), .rst(rst), .init(start), .en(crc_en), .bit_in(out_bit),
      .crc_q(crc_q), .crc_next(crc_next)
   );

   pf_bit_shifter u_ser (
      .clk(clk), .rst(rst), .load(load), .load_byte(load_byte),
      .advance(fire), .bit_out(out_bit), .valid(out_valid), .last(last)
   );

endmodule

// File: rtl/pf_framer_chk.sv
module pf_framer_chk #(
   parameter int PAYLOAD_BYTES = 256,
   parameter int PKT_BITS      = 2120,
   parameter int LEVEL_W       = 12,
   parameter int SEQ_W         = 16
) (
   input logic               clk,
   input logic               rst,
   input logic [LEVEL_W-1:0] fifo_level,
   input logic               fifo_rd_en,
   input logic               out_valid,
   input logic               out_bit,
   input logic               out_ready,
   input logic [SEQ_W-1:0]   seq_q
);

   logic        prev_valid;
   int unsigned bit_cnt, pop_cnt;
   logic        pkt_over;

   assign pkt_over = prev_valid & ~out_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_valid <= 1'b0;
         bit_cnt    <= 0;
         pop_cnt    <= 0;
      end else begin
         prev_valid <= out_valid;
         bit_cnt    <= pkt_over ? 0 : bit_cnt + ((out_valid && out_ready) ? 1 : 0);
         pop_cnt    <= pkt_over ? 0 : pop_cnt + (fifo_rd_en ? 1 : 0);
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && !fifo_rd_en));

   // R2
   start_level_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !prev_valid) |-> ($past(fifo_level) >= LEVEL_W'(PAYLOAD_BYTES)));

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_rd_en |-> (fifo_level != '0));

   // R5
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_over |-> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));

   // R6
   pop_count_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_over |-> (pop_cnt == PAYLOAD_BYTES));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

   // R9
   pkt_bits_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_over |-> (bit_cnt == PKT_BITS));

endmodule

bind pf_packet_framer pf_framer_chk #(
   .PAYLOAD_BYTES(PAYLOAD_BYTES),
   .PKT_BITS(8 * PKT_B),
   .LEVEL_W(LEVEL_W),
   .SEQ_W(SEQ_W)
) u_chk (
   .clk(clk), .rst(rst), .fifo_level(fifo_level), .fifo_rd_en(fifo_rd_en),
   .out_valid(out_valid), .out_bit(out_bit), .out_ready(out_ready), .seq_q(seq_q)
);

// File: tb/tb_pf_packet_framer.sv
`timescale 1ns/100ps
module tb_pf_packet_framer;

   localparam int PAY      = 256;
   localparam int PKT_BITS = 8 * (4 + 1 + 2 + PAY + 2);

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] fifo_level;
   logic [7:0]  fifo_data;
   logic        fifo_rd_en;
   logic [7:0]  dest_id = 8'h00;
   logic        out_valid, out_bit;
   logic        out_ready = 1'b1;

   always #2.5 clk = ~clk;

   pf_packet_framer dut (
      .clk(clk), .rst(rst), .fifo_level(fifo_level), .fifo_data(fifo_data),
      .fifo_rd_en(fifo_rd_en), .dest_id(dest_id), .out_valid(out_valid),
      .out_bit(out_bit), .out_ready(out_ready)
   );

   logic [7:0] mem [0:4095];
   int wr_ptr = 0, rd_ptr = 0;
   assign fifo_level = 12'(wr_ptr - rd_ptr);
   assign fifo_data  = mem[rd_ptr % 4096];

   bit   cap [0:16383];
   int   n_bits = 0;
   int   total = 0, bad = 0;
   bit   ready_rand = 0;
   logic [7:0] lfsr = 8'hA7;
   bit   pend_pop = 0;
   bit   prev_stall = 0, prev_sbit = 0;
   int   stall_bad = 0, stall_seen = 0, valid_seen = 0;

   // FIFO pop, ready pattern and bit capture, all away from the rising edge
   initial begin
      forever begin
         @(negedge clk);
         if (pend_pop) rd_ptr = rd_ptr + 1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         out_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
         #1;
         if (!rst) begin
            if (prev_stall && !(out_valid && out_bit == prev_sbit)) stall_bad++;
            if (out_valid) valid_seen++;
            if (out_valid && !out_ready) stall_seen++;
            prev_stall = out_valid && !out_ready;
            prev_sbit  = out_bit;
            if (out_valid && out_ready) begin
               cap[n_bits] = out_bit;
               n_bits++;
            end
            pend_pop = fifo_rd_en;
         end
      end
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_bytes(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         mem[wr_ptr % 4096] = 8'((i * 37 + seed * 11 + (i >> 3)) & 255);
         wr_ptr = wr_ptr + 1;
      end
   endtask

   function automatic longint field(input int pos, input int w);
      longint v = 0;
      for (int i = 0; i < w; i++) v = (v << 1) | longint'(cap[pos + i]);
      return v;
   endfunction

   function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb = r[15] ^ b[i];
         r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
      return r;
   endfunction

   task automatic check_packet(input int base, input logic [7:0] dst,
                               input logic [15:0] seq, input int pay_at);
      logic [15:0] crc = 16'hFFFF;
      int mism = 0;
      while (n_bits < base + PKT_BITS) @(negedge clk);
      chk("R3 access code", field(base, 32), 64'h1ACFFC1D);
      chk("R4 dest id", field(base + 32, 8), longint'(dst));
      chk("R5 sequence", field(base + 40, 16), longint'(seq));
      crc = crc_bits(crc, dst);
      crc = crc_bits(crc, seq[15:8]);
      crc = crc_bits(crc, seq[7:0]);
      for (int i = 0; i < PAY; i++) begin
         logic [7:0] e = mem[(pay_at + i) % 4096];
         if (field(base + 56 + 8 * i, 8) != longint'(e)) mism++;
         crc = crc_bits(crc, e);
      end
      chk("R6 payload mismatches", mism, 0);
      chk("R7 crc", field(base + 56 + 8 * PAY, 16), longint'(crc));
   endtask

   task automatic t_reset();
      chk("R1 valid in reset", out_valid, 0);
      chk("R1 rd_en in reset", fifo_rd_en, 0);
      @(negedge clk); rst = 1'b0;
      @(negedge clk); #1.2;
      chk("R1 valid after reset", out_valid, 0);
      chk("R1 rd_en after reset", fifo_rd_en, 0);
   endtask

   task automatic t_threshold_and_first();
      dest_id = 8'hA5;
      push_bytes(PAY - 1, 1);
      repeat (300) @(negedge clk);
      chk("R2 no valid below threshold", valid_seen, 0);
      chk("R2 no pop below threshold", rd_ptr, 0);
      @(negedge clk);
      push_bytes(1, 2);
      while (!out_valid) @(negedge clk);
      dest_id = 8'h3C;   // R4: change after start must be ignored
      check_packet(0, 8'hA5, 16'd0, 0);
      repeat (20) @(negedge clk);
      chk("R9 packet length", n_bits, PKT_BITS);
      chk("R9 idle after packet", out_valid, 0);
      chk("R6 pops per packet", rd_ptr, PAY);
   endtask

   task automatic t_stall();
      ready_rand = 1;
      dest_id = 8'h3C;
      push_bytes(PAY, 3);
      check_packet(PKT_BITS, 8'h3C, 16'd1, PAY);
      ready_rand = 0;
      repeat (20) @(negedge clk);
      chk("R8 stall hold errors", stall_bad, 0);
      chk("R8 stalls exercised", longint'(stall_seen > 50), 1);
      chk("R9 length under stalls", n_bits, 2 * PKT_BITS);
   endtask

   task automatic t_back_to_back();
      dest_id = 8'h5A;
      push_bytes(2 * PAY, 4);
      check_packet(2 * PKT_BITS, 8'h5A, 16'd2, 2 * PAY);
      check_packet(3 * PKT_BITS, 8'h5A, 16'd3, 3 * PAY);
      repeat (20) @(negedge clk);
      chk("R6 pops after four packets", rd_ptr, 4 * PAY);
      chk("R9 idle when fifo drained", out_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_threshold_and_first();
      t_stall();
      t_back_to_back();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule